// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory, 18 bits wide, that decodes its control pins at every rising clock edge on which the clock enable is asserted. A command can begin a read, begin a write, continue a burst, or deselect the device. When the clock enable is deasserted, the edge is a suspend edge and the whole block holds its state.

Address and control run two valid clock edges ahead of data, for reads and writes alike. Because of this, a read slot and a write slot never fall in the same cycle. Reads and writes can therefore follow each other on consecutive edges with no idle cycle between them.

A two-bit burst sequencer walks through four words, in either linear or interleaved order. The storage is a behavioural array split into two 9-bit byte lanes, and each lane can be written on its own.

Top module: `pipe_sram18`

## Requirements
- R1: At a valid edge (`clken_n`=0), a command with `adv_ld_n`=0, all three chip enables active (`ce_a_n`=0, `ce_b`=1, `ce_c_n`=0) and `wr_n`=1 accepts a read at `addr`. The stored word is driven on `dq` from the first to the second valid edge after acceptance, so it can be captured at the second.
- R2: The same command with `wr_n`=0 accepts a write. The word on `dq` at the second valid edge after acceptance is stored at the accepted address.
- R3: `bsel_n` is sampled with each write command and is active low. Bit 0 enables lane 0, which is `dq[8:0]` (data bits 7:0 at `dq[7:0]`, parity at `dq[8]`). Bit 1 enables lane 1, `dq[17:9]`. A disabled lane keeps its stored contents.
- R4: At a valid edge with `adv_ld_n`=1, the chip enables and `wr_n` are ignored. The access repeats the type of the last begun command and uses the next burst address. If the last begun command was a deselect, a continuation is also a deselect.
- R5: With `burst_lin`=1, the k-th beat of a burst (k = 0..3) uses low address bits (base + k) mod 4. The upper address bits stay unchanged.
- R6: With `burst_lin`=0, the k-th beat uses low address bits base XOR k. The upper address bits stay unchanged.
- R7: An edge with `clken_n`=1 changes nothing: no command is accepted, no write is performed, and the data slot in progress stays in place. Latency is counted in valid edges only.
- R8: A command with `adv_ld_n`=0 and any chip enable inactive performs no access, and the block leaves `dq` undriven in that command's data slot.
- R9: `dq` is driven only in a read slot while `oe_n`=0. `oe_n` acts combinationally.
- R10: After reset (`rst_n`=0), no access is pending and `dq` is undriven whatever the value of `oe_n`. The last begun command counts as a deselect.
- R11: The block never drives `dq` in a write slot. A begin-write and a begin-read on consecutive edges both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clken_n | input | 1 | Clock enable, active low; high suspends the edge |
| adv_ld_n | input | 1 | Low loads a new command, high continues the burst |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write enable, active low |
| bsel_n | input | 2 | Byte lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| dq | inout | 18 | Shared data bus, two 9-bit lanes |

## Verification
Corrupted burst state shows up in the second valid cycle after the faulty beat. It appears as the wrong word on a read, or it lands as a misplaced write that a later read of that address exposes. An error in the pipeline stages or in suspend handling shifts data by one slot. The very next read slot then returns a neighbour's word, or the block drives the bus in a slot where the bench drives a marker pattern. Wrong lane masking leaves stale or altered bytes, which appear at the next read of the same word.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_t;

  // low two address bits of burst beat 'step'
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       linear);
    if (linear) return base + step;
    else        return base ^ step;
  endfunction

  // active-low lane selects to active-high lane enables
  function automatic logic [LANES-1:0] lane_enables(input logic [LANES-1:0] sel_n);
    return ~sel_n;
  endfunction

endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_edge,
  input  logic              adv_ld_n,
  input  logic              ce_all,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  output op_kind_t          cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lanes,
  output op_kind_t          last_kind
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;

  assign step_nx = step_q + 2'd1;

  always_comb begin
    cmd_lanes = lane_enables(bsel_n);
    if (!adv_ld_n) begin
      cmd_addr = addr;
      if (!ce_all)   cmd_kind = OP_NONE;
      else if (wr_n) cmd_kind = OP_READ;
      else           cmd_kind = OP_WRITE;
    end else begin
      cmd_kind = last_kind;
      cmd_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nx, burst_lin)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= OP_NONE;
      base_q    <= '0;
      step_q    <= '0;
    end else if (valid_edge) begin
      if (!adv_ld_n) begin
        last_kind <= cmd_kind;
        base_q    <= addr;
        step_q    <= '0;
      end else begin
        step_q    <= step_nx;
      end
    end
  end

endmodule

// File: rtl/psr_op_pipe.sv
module psr_op_pipe
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_edge,
  input  op_kind_t          in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output op_kind_t          s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output op_kind_t          out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_lanes
);

  op_kind_t          kind_q  [STAGES];
  logic [ADDR_W-1:0] addr_q  [STAGES];
  logic [LANES-1:0]  lanes_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    op_kind_t          k_in;
    logic [ADDR_W-1:0] a_in;
    logic [LANES-1:0]  l_in;
    if (s == 0) begin : g_head
      assign k_in = in_kind;
      assign a_in = in_addr;
      assign l_in = in_lanes;
    end else begin : g_link
      assign k_in = kind_q[s-1];
      assign a_in = addr_q[s-1];
      assign l_in = lanes_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_q[s]  <= OP_NONE;
        addr_q[s]  <= '0;
        lanes_q[s] <= '0;
      end else if (valid_edge) begin
        kind_q[s]  <= k_in;
        addr_q[s]  <= a_in;
        lanes_q[s] <= l_in;
      end
    end
  end

  assign s1_kind   = kind_q[0];
  assign s1_addr   = addr_q[0];
  assign out_kind  = kind_q[STAGES-1];
  assign out_addr  = addr_q[STAGES-1];
  assign out_lanes = lanes_q[STAGES-1];

endmodule

// File: rtl/psr_lane_array.sv
module psr_lane_array
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[l])
        cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
    end
    assign rd_word[l*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/pipe_sram18.sv
module pipe_sram18
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clken_n,
  input  logic              adv_ld_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              wr_n,
  input  logic [1:0]        bsel_n,
  input  logic              oe_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [17:0]       dq
);

  logic              valid_edge;
  logic              ce_all;
  op_kind_t          cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lanes;
  op_kind_t          last_kind;
  op_kind_t          s1_kind;
  logic [ADDR_W-1:0] s1_addr;
  op_kind_t          s2_kind;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic [WORD_W-1:0] rd_word;
  logic              dq_drive;
  logic              wr_fire;

  assign valid_edge = !clken_n;
  assign ce_all     = !ce_a_n && ce_b && !ce_c_n;

  psr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_edge(valid_edge),
    .adv_ld_n  (adv_ld_n),
    .ce_all    (ce_all),
    .wr_n      (wr_n),
    .bsel_n    (bsel_n),
    .burst_lin (burst_lin),
    .addr      (addr),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_lanes (cmd_lanes),
    .last_kind (last_kind)
  );

  psr_op_pipe #(.ADDR_W(ADDR_W), .STAGES(2)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_edge(valid_edge),
    .in_kind   (cmd_kind),
    .in_addr   (cmd_addr),
    .in_lanes  (cmd_lanes),
    .s1_kind   (s1_kind),
    .s1_addr   (s1_addr),
    .out_kind  (s2_kind),
    .out_addr  (s2_addr),
    .out_lanes (s2_lanes)
  );

  assign wr_fire  = valid_edge && (s2_kind == OP_WRITE);
  assign dq_drive = (s2_kind == OP_READ) && !oe_n;

  psr_lane_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_lanes(s2_lanes),
    .wr_addr (s2_addr),
    .wr_word (dq),
    .rd_addr (s2_addr),
    .rd_word (rd_word)
  );

  assign dq = dq_drive ? rd_word : 'z;

endmodule

// File: rtl/psr_checker.sv
module psr_checker
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clken_n,
  input logic              adv_ld_n,
  input logic              ce_all,
  input logic              wr_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input op_kind_t          s1_kind,
  input logic [ADDR_W-1:0] s1_addr,
  input op_kind_t          s2_kind,
  input op_kind_t          last_kind,
  input logic              dq_drive
);

  AST_READ_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !adv_ld_n && ce_all && wr_n) |=> (s1_kind == OP_READ && s1_addr == $past(addr))); // R1

  AST_WRITE_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !adv_ld_n && ce_all && !wr_n) |=> (s1_kind == OP_WRITE && s1_addr == $past(addr))); // R2

  AST_BURST_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && adv_ld_n) |=> (s1_kind == $past(last_kind))); // R4

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clken_n |=> ($stable(s1_kind) && $stable(s2_kind) && $stable(s1_addr))); // R7

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !adv_ld_n && !ce_all) |=> (s1_kind == OP_NONE)); // R8

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !oe_n); // R9

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_kind == OP_WRITE) |-> !dq_drive); // R11

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!dq_drive); // R10
  end

endmodule

bind pipe_sram18 psr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clken_n  (clken_n),
  .adv_ld_n (adv_ld_n),
  .ce_all   (ce_all),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .addr     (addr),
  .s1_kind  (s1_kind),
  .s1_addr  (s1_addr),
  .s2_kind  (s2_kind),
  .last_kind(last_kind),
  .dq_drive (dq_drive)
);

// File: tb/pipe_sram18_test.sv
module pipe_sram18_test;

  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;
  localparam logic [17:0] KEEP = 18'h2A5A5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clken_n = 1'b0, adv_ld_n = 1'b0, ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic          wr_n = 1'b1, oe_n = 1'b0, burst_lin = 1'b1;
  logic [1:0]    bsel_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [17:0]   tb_dq = '0;
  logic          tb_drv = 1'b0;
  wire  [17:0]   dq;

  assign dq = tb_drv ? tb_dq : 'z;

  pipe_sram18 #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .adv_ld_n(adv_ld_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .wr_n(wr_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .burst_lin(burst_lin), .addr(addr), .dq(dq)
  );

  always #10 clk = ~clk;   // 50 MHz

  // reference state: kinds 0 none, 1 read, 2 write
  logic [17:0] model [WORDS];
  int p1k = 0, p1a = 0, p2k = 0, p2a = 0;
  logic [1:0] p1m = 0, p2m = 0;
  int last_k = 0, base_a = 0, beat = 0, ce_rot = 0;
  int nchk = 0, nfail = 0;
  string cur_req = "R10";
  bit finished = 0;

  task automatic chk(input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: dq=%h expected=%h", cur_req, act, exp);
    end
  endtask

  task automatic cyc(input bit cen, input bit adv, input bit ce_ok, input bit we,
                     input logic [1:0] bs, input int a, input bit oe, input bit lin);
    int nk, na;
    @(negedge clk);
    clken_n = cen; adv_ld_n = adv; wr_n = we; bsel_n = bs; addr = a[AW-1:0];
    oe_n = oe; burst_lin = lin;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    if (!ce_ok) begin
      ce_rot = (ce_rot + 1) % 3;
      if (ce_rot == 0) ce_a_n = 1'b1; else if (ce_rot == 1) ce_b = 1'b0; else ce_c_n = 1'b1;
    end
    if (p2k == 2) begin tb_dq = 18'($urandom); tb_drv = 1'b1; end
    else if (p2k == 1 && !oe) tb_drv = 1'b0;
    else begin tb_dq = KEEP; tb_drv = 1'b1; end
    #2;
    if (p2k == 1 && !oe) chk(dq, model[p2a]);
    else if (p2k != 2)   chk(dq, KEEP);
    if (!cen) begin
      if (p2k == 2) begin
        if (p2m[0]) model[p2a][8:0]  = tb_dq[8:0];
        if (p2m[1]) model[p2a][17:9] = tb_dq[17:9];
      end
      if (!adv) begin
        nk = !ce_ok ? 0 : (we ? 1 : 2);
        na = a % WORDS;
        last_k = nk; base_a = na; beat = 0;
      end else begin
        beat = (beat + 1) % 4;
        nk = last_k;
        if (lin) na = (base_a & ~3) | ((base_a + beat) & 3);
        else     na = (base_a & ~3) | ((base_a ^ beat) & 3);
      end
      p2k = p1k; p2a = p1a; p2m = p1m;
      p1k = nk;  p1a = na;  p1m = ~bs;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 2'b11, 0, 0, 1);
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R10: bus quiet during and after reset, even with oe_n low
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R10";
    idle(3);

    // R2 then R1: fill every word, read every word back
    cur_req = "R2";
    for (int a = 0; a < WORDS; a++) cyc(0, 0, 1, 0, 2'b00, a, 0, 1);
    cur_req = "R1";
    for (int a = 0; a < WORDS; a++) cyc(0, 0, 1, 1, 2'b11, a, 0, 1);
    idle(2);

    // R3: every lane-select pattern, read back
    cur_req = "R3";
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < WORDS; a += 3) begin
        cyc(0, 0, 1, 0, 2'(m), a, 0, 1);
        idle(2);
        cyc(0, 0, 1, 1, 2'b11, a, 0, 1);
        idle(2);
      end

    // R4: continuations ignore enables and wr_n; continuation after deselect
    cur_req = "R4";
    cyc(0, 0, 1, 0, 2'b00, 5, 0, 1);
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 2'b00, 9, 0, 1);
    cyc(0, 0, 1, 1, 2'b11, 5, 0, 1);
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 2'b00, 2, 0, 1);
    cyc(0, 0, 0, 0, 2'b00, 3, 0, 1);
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 0, 2'b00, 3, 0, 1);
    idle(2);
    for (int a = 0; a < WORDS; a++) cyc(0, 0, 1, 1, 2'b11, a, 0, 1);
    idle(2);

    // R5 linear and R6 interleaved bursts from every base, write then read
    for (int l = 1; l >= 0; l--) begin
      cur_req = l ? "R5" : "R6";
      for (int b = 0; b < WORDS; b++) begin
        cyc(0, 0, 1, 0, 2'b00, b, 0, l[0]);
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 2'b00, 0, 0, l[0]);
        cyc(0, 0, 1, 1, 2'b11, b, 0, l[0]);
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 2'b11, 0, 0, l[0]);
      end
      idle(2);
    end

    // R11: write/read alternation with no idle slot
    cur_req = "R11";
    for (int i = 0; i < 64; i++) begin
      cyc(0, 0, 1, 0, 2'b00, i % WORDS, 0, 1);
      cyc(0, 0, 1, 1, 2'b11, (i * 7) % WORDS, 0, 1);
    end
    idle(2);

    // R9: oe_n high hides read slots
    cur_req = "R9";
    for (int i = 0; i < 32; i++) cyc(0, 0, 1, 1, 2'b11, i % WORDS, i % 2, 1);
    idle(2);

    // R8: deselects mixed with reads
    cur_req = "R8";
    for (int i = 0; i < 32; i++) cyc(0, 0, i % 3 != 0, 1, 2'b11, i % WORDS, 0, 1);
    idle(2);

    // R7: random traffic with suspend edges
    cur_req = "R7";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 6) != 0,
          $urandom % 2, 2'($urandom), int'($urandom % WORDS),
          ($urandom % 8) == 0, $urandom % 2);
    idle(3);
    for (int a = 0; a < WORDS; a++) cyc(0, 0, 1, 1, 2'b11, a, 0, 1);
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule